// File: doc/BRIEF.md
# BCD Pulse-Swallow Programmable Divider

This block is the programmable divider of a synthesizer loop. It takes a frequency selection as packed BCD digits, takes a fixed decimal offset off that number with borrows carried from digit to digit, and turns every corrected digit into its nines complement. Those complements preset a chain of synchronous up-counting decade stages. The least significant stage acts as the swallow counter and the upper stages act as the main counter. An internal dual-modulus prescaler divides by 11 while swallowing and by 10 afterwards, so the input clock is divided by exactly the corrected number N. One pulse per division cycle goes to the phase/frequency detector. A separate fixed divider turns the master reference clock into the comparison pulse.

Control is a three-state machine. IDLE is entered at reset and waits for a legal selection. START (IDLE→SWALLOW, or IDLE→MAIN when the swallow digit is zero) loads the presets. SWALLOW holds the prescaler at 11 until the swallow stage reaches nine, and SWALLOW→MAIN happens on that prescaler boundary. RELOAD (SWALLOW or MAIN → SWALLOW/MAIN) fires on the prescaler boundary where the main stages would step into all nines. It emits the output pulse and loads fresh presets. A selection is sampled only at START or RELOAD. An illegal selection raises an error flag, and the previous preset is loaded again.

Top module: `bcd_swallow_divider`

## Requirements
- R1: With a legal three-digit selection S, `div_pulse` rises once every N = S − 4 cycles of `clk` (for example 316 gives 312). The stages are preset with the nines complement of the digits of N.
- R2: The offset subtraction borrows across digit boundaries: 302 gives 298, 100 gives 96, and 999 gives 995.
- R3: `div_pulse` is high for exactly one `clk` cycle per division cycle. It is never high on two consecutive cycles.
- R4: Let A be the units digit of N. In each division cycle `mod_ctl` is high for the first 11·A cycles, starting with the `div_pulse` cycle, and low for the remaining 10·(N/10 − A) cycles. `mod_ctl` falls only at a prescaler boundary.
- R5: When A is 0 (for example selection 314, N = 310), `mod_ctl` stays low for the whole division cycle.
- R6: A selection changed in the middle of a division cycle leaves that cycle's length unchanged. It takes effect from the next RELOAD.
- R7: The selection `sel_bcd` packs digits as hundreds in [11:8], tens in [7:4] and units in [3:0]. If any nibble holds 10 to 15, `sel_err` is high from the following clock, and RELOAD keeps loading the previous preset, so the period stays unchanged.
- R8: A selection below 4 (for example 003) cannot have the offset removed. It is treated like R7: `sel_err` goes high and the previous preset is kept.
- R9: During reset `div_pulse`, `mod_ctl` and `sel_err` are low. After reset the block stays in IDLE without pulses until a legal selection is present, then pulses with period N.
- R10: `ref_pulse` is high for one `ref_clk` cycle out of every 12.
- R11: `sel_err` returns low one clock after a legal selection is applied again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider input clock, already pre-divided by a fixed factor upstream |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| sel_bcd | input | 12 | Frequency selection, three BCD digits, hundreds in the top nibble |
| ref_clk | input | 1 | Master reference clock |
| div_pulse | output | 1 | One-cycle pulse at the end of each division cycle, sent to the detector |
| mod_ctl | output | 1 | Dual-modulus control: high selects divide by 11 (swallow phase) |
| sel_err | output | 1 | Selection holds a non-BCD digit or is below the offset |
| ref_pulse | output | 1 | Comparison reference pulse, one per 12 `ref_clk` cycles |

## Verification
A wrong preset digit, a lost borrow or a missed carry between decade stages shows up at the ports as a division period that is off by a multiple of 1, 10 or 100 input cycles. This error appears at the very next `div_pulse`, at most about a thousand cycles after the faulty load. A swallow phase that ends too early or too late changes the count of `mod_ctl` high cycles in the same period, in steps of 11. A selection that was latched too early, or was not held on error, gives a wrong period for the division cycle that was already running, so every period is measured on both sides of each selection change.

// File: rtl/bcd_swallow_pkg.sv
package bcd_swallow_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } div_state_e;

    localparam logic [3:0] DEC_TOP = 4'd9;

    function automatic logic [3:0] nines_of(input logic [3:0] d);
        return DEC_TOP - d;
    endfunction

endpackage

// File: rtl/preset_encoder.sv
module preset_encoder
    import bcd_swallow_pkg::*;
#(
    parameter int SEL_DIG    = 3,
    parameter int OFFSET     = 4,
    parameter int FIX_MSD_EN = 0,
    parameter int FIX_MSD    = 4,
    localparam int CH_DIG    = SEL_DIG + FIX_MSD_EN
) (
    input  logic [4*SEL_DIG-1:0] sel,
    output logic [4*CH_DIG-1:0]  preset,
    output logic                 ok
);

    logic [4*SEL_DIG-1:0] corr;

    always_comb begin
        logic       bad;
        logic       brw;
        logic [3:0] dig;
        int         t;
        bad  = 1'b0;
        brw  = 1'b0;
        corr = '0;
        for (int i = 0; i < SEL_DIG; i++) begin
            dig = sel[4*i +: 4];
            if (dig > DEC_TOP) bad = 1'b1;
            t = int'(dig) - ((OFFSET / (10 ** i)) % 10) - int'(brw);
            if (t < 0) begin
                t   = t + 10;
                brw = 1'b1;
            end else begin
                brw = 1'b0;
            end
            corr[4*i +: 4] = 4'(t);
        end
        ok = !bad && !brw;
    end

    for (genvar g = 0; g < SEL_DIG; g++) begin : g_cmp
        assign preset[4*g +: 4] = nines_of(corr[4*g +: 4]);
    end

    if (FIX_MSD_EN != 0) begin : g_fixed
        assign preset[4*SEL_DIG +: 4] = nines_of(4'(FIX_MSD));
    end

endmodule

// File: rtl/decade_stage.sv
module decade_stage (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [3:0] ld_val,
    input  logic       inc,
    output logic [3:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= 4'd0;
        else if (load)    q <= ld_val;
        else if (inc)     q <= (q == 4'd9) ? 4'd0 : q + 4'd1;
    end

endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler #(
    parameter int BASE = 10,
    localparam int CW  = $clog2(BASE + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic mod_hi,
    output logic tick
);

    logic [CW-1:0] cnt;

    assign tick = (cnt == (mod_hi ? CW'(BASE) : CW'(BASE - 1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (restart || tick) cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
    parameter int DIV = 12,
    localparam int CW = $clog2(DIV)
) (
    input  logic ref_clk,
    input  logic rst_n,
    output logic pulse
);

    logic [CW-1:0] cnt;

    assign pulse = (cnt == CW'(DIV - 1));

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (pulse) cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/bcd_swallow_divider.sv
module bcd_swallow_divider
    import bcd_swallow_pkg::*;
#(
    parameter int SEL_DIG    = 3,
    parameter int OFFSET     = 4,
    parameter int FIX_MSD_EN = 0,
    parameter int FIX_MSD    = 4,
    parameter int REF_DIV    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [4*SEL_DIG-1:0] sel_bcd,
    input  logic                 ref_clk,
    output logic                 div_pulse,
    output logic                 mod_ctl,
    output logic                 sel_err,
    output logic                 ref_pulse
);

    localparam int CH_DIG     = SEL_DIG + FIX_MSD_EN;
    localparam int PW         = 4 * CH_DIG;
    localparam int PRESC_BASE = 10;

    div_state_e    state, state_n;
    logic [PW-1:0] enc_preset;
    logic          enc_ok;
    logic [PW-1:0] preset_q;
    logic [PW-1:0] ld_val;
    logic [PW-1:0] cnt_q;
    logic [CH_DIG-1:0] inc;
    logic          ptick;
    logic          up_last;
    logic          start;
    logic          reload;
    logic          load;
    div_state_e    after_load;

    preset_encoder #(
        .SEL_DIG(SEL_DIG), .OFFSET(OFFSET),
        .FIX_MSD_EN(FIX_MSD_EN), .FIX_MSD(FIX_MSD)
    ) u_enc (
        .sel(sel_bcd), .preset(enc_preset), .ok(enc_ok)
    );

    dual_mod_prescaler #(.BASE(PRESC_BASE)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(start),
        .mod_hi(mod_ctl), .tick(ptick)
    );

    ref_divider #(.DIV(REF_DIV)) u_ref (
        .ref_clk(ref_clk), .rst_n(rst_n), .pulse(ref_pulse)
    );

    // main stages would step into all nines on this prescaler tick
    always_comb begin
        up_last = (cnt_q[7:4] == 4'd8);
        for (int i = 2; i < CH_DIG; i++) begin
            if (cnt_q[4*i +: 4] != DEC_TOP) up_last = 1'b0;
        end
    end

    assign start  = (state == ST_IDLE) && enc_ok;
    assign reload = ptick && up_last && (state != ST_IDLE);
    assign load   = start || reload;
    assign ld_val = enc_ok ? enc_preset : preset_q;
    assign after_load = (ld_val[3:0] != DEC_TOP) ? ST_SWALLOW : ST_MAIN;

    assign inc[0] = ptick && (state == ST_SWALLOW);
    assign inc[1] = ptick && (state != ST_IDLE);
    for (genvar g = 2; g < CH_DIG; g++) begin : g_carry
        assign inc[g] = inc[g-1] && (cnt_q[4*(g-1) +: 4] == DEC_TOP);
    end

    for (genvar g = 0; g < CH_DIG; g++) begin : g_stage
        decade_stage u_dig (
            .clk(clk), .rst_n(rst_n), .load(load),
            .ld_val(ld_val[4*g +: 4]), .inc(inc[g]),
            .q(cnt_q[4*g +: 4])
        );
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (start) state_n = after_load;
            end
            ST_SWALLOW: begin
                if (reload)                                   state_n = after_load;
                else if (ptick && (cnt_q[3:0] == 4'd8))       state_n = ST_MAIN;
            end
            ST_MAIN: begin
                if (reload) state_n = after_load;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mod_ctl = (state == ST_SWALLOW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preset_q  <= {CH_DIG{DEC_TOP}};
            div_pulse <= 1'b0;
            sel_err   <= 1'b0;
        end else begin
            if (load && enc_ok) preset_q <= enc_preset;
            div_pulse <= reload;
            sel_err   <= !enc_ok;
        end
    end

endmodule

// File: rtl/bcd_swallow_divider_chk.sv
module bcd_swallow_divider_chk #(
    parameter int PW = 12
) (
    input logic          clk,
    input logic          ref_clk,
    input logic          rst_n,
    input logic          div_pulse,
    input logic          mod_ctl,
    input logic          ref_pulse,
    input logic          ptick,
    input logic          load,
    input logic [PW-1:0] cnt_q,
    input logic [PW-1:0] preset_q
);

    logic dig_ok;
    always_comb begin
        dig_ok = 1'b1;
        for (int i = 0; i < PW / 4; i++) begin
            if (cnt_q[4*i +: 4] > 4'd9) dig_ok = 1'b0;
        end
    end

    AST_DIGITS_DECIMAL: assert property (@(posedge clk) disable iff (!rst_n) dig_ok); // R1
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) div_pulse |=> !div_pulse); // R3
    AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) div_pulse |-> $past(ptick)); // R3
    AST_MOD_FALL_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) $fell(mod_ctl) |-> $past(ptick)); // R4
    AST_MOD_NEEDS_SWALLOW_LEFT: assert property (@(posedge clk) disable iff (!rst_n) mod_ctl |-> (cnt_q[3:0] != 4'd9)); // R4
    AST_PRESET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !load |=> $stable(preset_q)); // R6
    AST_REF_SINGLE: assert property (@(posedge ref_clk) disable iff (!rst_n) ref_pulse |=> !ref_pulse); // R10

endmodule

bind bcd_swallow_divider bcd_swallow_divider_chk #(.PW(PW)) u_chk (
    .clk(clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .div_pulse(div_pulse), .mod_ctl(mod_ctl), .ref_pulse(ref_pulse),
    .ptick(ptick), .load(load), .cnt_q(cnt_q), .preset_q(preset_q)
);

// File: tb/tb_bcd_swallow_divider.sv
`timescale 1ns/1ps
module tb_bcd_swallow_divider;

    logic        clk = 1'b0;
    logic        ref_clk = 1'b0;
    logic        rst_n;
    logic [11:0] sel;
    logic        div_pulse, mod_ctl, sel_err, ref_pulse;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    int cur_n;

    always #2.5 clk = ~clk;
    always #4   ref_clk = ~ref_clk;

    bcd_swallow_divider dut (
        .clk(clk), .rst_n(rst_n), .sel_bcd(sel), .ref_clk(ref_clk),
        .div_pulse(div_pulse), .mod_ctl(mod_ctl), .sel_err(sel_err),
        .ref_pulse(ref_pulse)
    );

    function automatic logic [11:0] to_bcd(input int v);
        return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic sync_pulse();
        @(negedge clk);
        while (!div_pulse) @(negedge clk);
    endtask

    // starts on a pulse cycle, ends on the next pulse cycle
    task automatic measure(output int len, output int mhi);
        len = 0;
        mhi = 0;
        do begin
            mhi += int'(mod_ctl);
            len++;
            @(negedge clk);
        end while (!div_pulse);
    endtask

    task automatic run_sel(input int v, input string req);
        int len, mhi, n;
        n = v - 4;
        sel = to_bcd(v);
        measure(len, mhi);
        chk(len == cur_n, "R6", "period in flight after change", len, cur_n);
        measure(len, mhi);
        chk(len == n, req, "period for new selection", len, n);
        chk(mhi == 11 * (n % 10), (n % 10 == 0) ? "R5" : "R4",
            "mod_ctl high cycles", mhi, 11 * (n % 10));
        cur_n = n;
    endtask

    initial begin
        int len, mhi, n;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0;
        sel   = 12'h316;
        repeat (3) @(negedge clk);
        chk(div_pulse == 1'b0, "R9", "div_pulse in reset", int'(div_pulse), 0);
        chk(mod_ctl == 1'b0, "R9", "mod_ctl in reset", int'(mod_ctl), 0);
        chk(sel_err == 1'b0, "R9", "sel_err in reset", int'(sel_err), 0);
        rst_n = 1'b1;

        // R10: reference divider
        @(negedge ref_clk);
        while (!ref_pulse) @(negedge ref_clk);
        n = 0;
        do begin
            @(negedge ref_clk);
            n++;
            if (n == 1) chk(ref_pulse == 1'b0, "R10", "ref pulse width", int'(ref_pulse), 0);
        end while (!ref_pulse && n < 40);
        chk(n == 12, "R10", "ref pulse spacing", n, 12);

        // R1: first selection
        sync_pulse();
        measure(len, mhi);
        chk(len == 312, "R1", "period for 316", len, 312);
        chk(mhi == 22, "R4", "mod_ctl high cycles for 312", mhi, 22);
        cur_n = 312;

        run_sel(302, "R2");
        run_sel(100, "R2");
        run_sel(999, "R2");
        run_sel(314, "R5");
        run_sel(176, "R1");
        run_sel(264, "R1");

        // R7: non-BCD nibble keeps the old preset
        sel = 12'h3A5;
        measure(len, mhi);
        chk(sel_err == 1'b1, "R7", "sel_err on nibble 10", int'(sel_err), 1);
        chk(len == cur_n, "R7", "period in flight", len, cur_n);
        measure(len, mhi);
        chk(len == cur_n, "R7", "period after bad reload", len, cur_n);

        // R8: below the offset
        sel = 12'h003;
        measure(len, mhi);
        chk(sel_err == 1'b1, "R8", "sel_err on underflow", int'(sel_err), 1);
        measure(len, mhi);
        chk(len == cur_n, "R8", "period after underflow reload", len, cur_n);

        // R11: error clears one clock after a legal selection
        sel = to_bcd(450);
        @(negedge clk);
        chk(sel_err == 1'b0, "R11", "sel_err after legal selection", int'(sel_err), 0);
        sync_pulse();
        measure(len, mhi);
        chk(len == 446, "R11", "period after recovery", len, 446);
        cur_n = 446;

        for (int k = 0; k < 8; k++) begin
            run_sel(int'($urandom_range(999, 100)), "R1");
        end

        // R9: idle until a legal selection arrives
        rst_n = 1'b0;
        sel   = 12'h0F0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            n += int'(div_pulse);
        end
        chk(n == 0, "R9", "pulses while idle", n, 0);
        sel = to_bcd(500);
        sync_pulse();
        measure(len, mhi);
        chk(len == 496, "R9", "period after leaving idle", len, 496);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule